// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronised Updates

The block drives four independent pulse-width outputs from a single master clock. Each channel has its own settings: a clock divider setting, a choice between edge-aligned and centre-aligned counting, and a start level for the output. Each channel also holds a period length, a high-time length and one staging register. Software sets up a channel while it is stopped. It writes the period and the duty directly, then starts any group of channels with one masked write. Channels started by the same write count in phase.

While a channel runs, its period and duty registers are locked. A new value goes into the channel's staging register instead. A mode bit chooses whether that value replaces the period or the duty. The replacement happens on the clock edge that ends the current period, so the output never shows a cycle with a half-applied setting. The duty is clamped so that it never exceeds the period. Each channel also raises a sticky end-of-period flag, which software clears by writing a 1 to it.

The configuration port is a plain write strobe with an address and data. It has no back-pressure: every write is taken on the clock edge where `wr_en` is high. Nothing flows out as a stream. The outputs are levels, valid after every clock edge.

Top module: `pwm_quad`

## Requirements
- R1: After reset every channel is stopped. Its mode is all zero, its period is 1 and its duty is 0, so all outputs and all end-of-period flags are 0.
- R2: A write to address 0 starts every channel whose bit is set in `wr_data[3:0]`. On that same edge each started counter is cleared to 0, so channels started together run in phase. A set bit for a channel that is already running has no effect on it. A write to address 1 stops every channel whose bit is set.
- R3: In edge-aligned mode (mode bit 4 = 0) the counter advances once per tick, from 0 to period-1, and then wraps to 0. The output is at its start level while the count is below the duty, and at the opposite level otherwise.
- R4: In centre-aligned mode (mode bit 4 = 1) the counter counts up from 0 to the period and then down to 0. One period therefore lasts 2×period ticks. The output rule of R3 applies to this count.
- R5: Mode bit 5 is the start level. A stopped channel drives its start level.
- R6: Mode bits [3:0] select a tick every 2^n master clocks, for n from 0 to 10. Values above 10 act as 10.
- R7: Channel c occupies addresses 8+4c to 11+4c: offset 0 is the mode, 1 the period, 2 the duty and 3 the staging register. Writes to the mode, period or duty register of a running channel are ignored.
- R8: A write to the staging register is held until the edge that ends the current period. In edge-aligned mode that is the wrap. In centre-aligned mode it is the return to 0. If several writes arrive in one period, the last one is used.
- R9: Mode bit 6 steers the staged value: 1 replaces the period and 0 replaces the duty.
- R10: The duty never exceeds the period. A duty value, written directly or staged, is clamped to the period. A new period that is smaller than the duty also lowers the duty to it. A period of 0 is stored as 1.
- R11: Flag bit c is set on every period end of channel c and stays set until a write to address 2 with bit c set. If a clear and a new period end fall on the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data, also the channel mask for addresses 0 to 2 |
| pwm_o | output | 4 | Pulse-width outputs, one per channel |
| pe_flag | output | 4 | Sticky end-of-period flags |

## Verification
The assertions check on every cycle that the duty never exceeds the period and that the period is never zero. They also check that a running channel's mode, period and duty change only on a period-end edge, and that the counter stays inside its range for the chosen alignment. Finally, they check that a start write leaves every masked channel running, that a stop write leaves none running, and that flags are sticky and set on every period end.

What the bench scenarios alone can show is the shape of the waveforms:
- the exact level pattern for random periods, duties, alignments and start levels;
- that channels started together stay in phase;
- the cycle on which a staged value takes effect, and that the last staged write wins;
- the clamping seen at the output;
- the flag interval for each divider setting.

// File: rtl/pwm_quad_pkg.sv
`timescale 1ns/1ps
package pwm_quad_pkg;
  // global write addresses (data carries a channel mask)
  localparam int ADR_START    = 0;
  localparam int ADR_STOP     = 1;
  localparam int ADR_FLAG_CLR = 2;
  // first per-channel block; each channel owns four consecutive addresses
  localparam int CH_BASE      = 8;
  localparam logic [1:0] OFS_MODE   = 2'd0;
  localparam logic [1:0] OFS_PERIOD = 2'd1;
  localparam logic [1:0] OFS_DUTY   = 2'd2;
  localparam logic [1:0] OFS_STAGE  = 2'd3;

  typedef struct packed {
    logic       upd_to_period; // bit 6
    logic       pol;           // bit 5
    logic       center;        // bit 4
    logic [3:0] div_sel;       // bits 3:0
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int DIV_STEPS = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [DIV_STEPS-1:0] tick_vec
);
  localparam int CW = (DIV_STEPS > 1) ? DIV_STEPS - 1 : 1;

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + CW'(1);
  end

  assign tick_vec[0] = 1'b1;

  // tick n fires when the low n bits of the free-running count are all ones
  generate
    for (genvar k = 1; k < DIV_STEPS; k++) begin : g_tick
      assign tick_vec[k] = &div_q[k-1:0];
    end
  endgenerate

  generate
    if (DIV_STEPS > 1) begin : g_chk
      AST_SLOW_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_vec[DIV_STEPS-1] |=> !tick_vec[DIV_STEPS-1]); // R6
    end
  endgenerate
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DIV_STEPS = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_STEPS-1:0] tick_vec,
  input  logic                 wr_mode,
  input  logic                 wr_period,
  input  logic                 wr_duty,
  input  logic                 wr_stage,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 start,
  input  logic                 stop,
  output logic                 pwm_o,
  output logic                 period_end,
  output logic                 running
);
  localparam logic [3:0]       SEL_MAX = 4'(DIV_STEPS - 1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  mode_t            mode_q;
  logic [CNT_W-1:0] period_q, duty_q, cnt_q, stage_q;
  logic             pend_q, en_q, down_q;

  logic [3:0]       sel_eff;
  logic             tick, step, ev;
  logic [CNT_W-1:0] cnt_d;
  logic             down_d;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  function automatic logic [CNT_W-1:0] lesser(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // divider selection, clamped to the slowest tick
  always_comb begin
    sel_eff = (mode_q.div_sel > SEL_MAX) ? SEL_MAX : mode_q.div_sel;
    tick    = tick_vec[sel_eff];
    step    = en_q & tick;
  end

  // next count and period-end detection
  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    ev     = 1'b0;
    if (step) begin
      if (!mode_q.center) begin
        if (cnt_q >= period_q - ONE) begin
          cnt_d = '0;
          ev    = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (!down_q) begin
        if (cnt_q >= period_q) begin
          if (cnt_q <= ONE) begin
            cnt_d = '0;
            ev    = 1'b1;
          end else begin
            cnt_d  = cnt_q - ONE;
            down_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_d  = '0;
          down_d = 1'b0;
          ev     = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  // run state and counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (start && !en_q) begin
      en_q   <= 1'b1;
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (stop) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  // settings: direct writes while stopped, staged transfer at period end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      period_q <= ONE;
      duty_q   <= '0;
    end else if (!en_q) begin
      if (wr_mode)   mode_q <= mode_t'(wr_data[MODE_W-1:0]);
      if (wr_period) begin
        period_q <= at_least_one(wr_data);
        duty_q   <= lesser(duty_q, at_least_one(wr_data));
      end
      if (wr_duty)   duty_q <= lesser(wr_data, period_q);
    end else if (ev && pend_q) begin
      if (mode_q.upd_to_period) begin
        period_q <= at_least_one(stage_q);
        duty_q   <= lesser(duty_q, at_least_one(stage_q));
      end else begin
        duty_q   <= lesser(stage_q, period_q);
      end
    end
  end

  // staging register: last write wins, consumed at period end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      stage_q <= '0;
    end else if (wr_stage) begin
      pend_q  <= 1'b1;
      stage_q <= wr_data;
    end else if (ev) begin
      pend_q  <= 1'b0;
    end
  end

  assign running    = en_q;
  assign period_end = ev;
  assign pwm_o      = en_q ? ((cnt_q < duty_q) ? mode_q.pol : ~mode_q.pol) : mode_q.pol;

  AST_DUTY_LE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= period_q); // R10
  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_q != '0); // R10
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(mode_q)); // R7
  AST_TIMING_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && !$past(ev)) |-> ($stable(period_q) && $stable(duty_q))); // R8
  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !mode_q.center) |-> (cnt_q < period_q)); // R3
  AST_CENTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q.center) |-> (cnt_q <= period_q)); // R4
  AST_STAGE_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !wr_stage) |=> !pend_q); // R8
endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 16,
  parameter int DIV_STEPS = 11,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] pe_flag
);
  localparam int BLK_W = ADDR_W - 2;

  logic [DIV_STEPS-1:0] tick_vec;
  logic [NUM_CH-1:0]    mask, running, pe;
  logic                 start_wr, stop_wr, clr_wr;

  assign mask     = wr_data[NUM_CH-1:0];
  assign start_wr = wr_en && (wr_addr == ADDR_W'(ADR_START));
  assign stop_wr  = wr_en && (wr_addr == ADDR_W'(ADR_STOP));
  assign clr_wr   = wr_en && (wr_addr == ADDR_W'(ADR_FLAG_CLR));

  pwm_prescaler #(.DIV_STEPS(DIV_STEPS)) presc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_vec (tick_vec)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit;
      assign hit = wr_en && (wr_addr[ADDR_W-1:2] == BLK_W'(CH_BASE / 4 + g));

      pwm_channel #(.CNT_W(CNT_W), .DIV_STEPS(DIV_STEPS)) ch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_vec   (tick_vec),
        .wr_mode    (hit && (wr_addr[1:0] == OFS_MODE)),
        .wr_period  (hit && (wr_addr[1:0] == OFS_PERIOD)),
        .wr_duty    (hit && (wr_addr[1:0] == OFS_DUTY)),
        .wr_stage   (hit && (wr_addr[1:0] == OFS_STAGE)),
        .wr_data    (wr_data),
        .start      (start_wr && mask[g]),
        .stop       (stop_wr && mask[g]),
        .pwm_o      (pwm_o[g]),
        .period_end (pe[g]),
        .running    (running[g])
      );
    end
  endgenerate

  // sticky flags; a new period end beats a same-edge clear
  always_ff @(posedge clk) begin
    if (!rst_n) pe_flag <= '0;
    else        pe_flag <= (pe_flag & ~(clr_wr ? mask : '0)) | pe;
  end

  AST_START_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> ((running & $past(mask)) == $past(mask))); // R2
  AST_STOP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> ((running & $past(mask)) == '0)); // R2
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|pe) |=> ((pe_flag & $past(pe)) == $past(pe))); // R11
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((pe_flag & $past(pe_flag)) == $past(pe_flag))); // R11
endmodule

// File: tb/pwm_quad_tb_top.sv
`timescale 1ns/1ps
module pwm_quad_tb_top;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 5;

  localparam int A_START = 0, A_STOP = 1, A_CLR = 2, A_BASE = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [NUM_CH-1:0] pwm_o, pe_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  pwm_quad dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_o   (pwm_o),
    .pe_flag (pe_flag)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int mk_mode(input int sel, input bit center, input bit pol, input bit tgt);
    return (int'(tgt) << 6) | (int'(pol) << 5) | (int'(center) << 4) | (sel & 15);
  endfunction

  task automatic cfg(input int ch, input int mode, input int p, input int d);
    wr(A_BASE + 4*ch + 0, mode);
    wr(A_BASE + 4*ch + 1, p);
    wr(A_BASE + 4*ch + 2, d);
  endtask

  // expected level j ticks after start, from R3/R4/R5
  function automatic bit exp_level(input bit center, input int p, input int d,
                                   input bit pol, input int j);
    int c;
    if (center) begin
      int ph;
      ph = j % (2*p);
      c  = (ph <= p) ? ph : 2*p - ph;
    end else begin
      c = j % p;
    end
    return (c < d) ? pol : !pol;
  endfunction

  task automatic check_wave(input int ch, input int j0, input int n, input bit center,
                            input int p, input int d, input bit pol, input string req);
    int bad;
    int a, e;
    bad = -1; a = 0; e = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_o[ch] !== exp_level(center, p, d, pol, j0 + k) && bad < 0) begin
        bad = k;
        a   = int'(pwm_o[ch]);
        e   = int'(exp_level(center, p, d, pol, j0 + k));
      end
      @(negedge clk);
    end
    check(bad < 0, req, $sformatf("ch%0d level at tick %0d", ch, j0 + bad), a, e);
  endtask

  // clocks between two consecutive period ends, measured through the flag
  task automatic measure(input int ch, input int exp, input string req);
    int n;
    n = 0;
    while (!pe_flag[ch] && n < 5000) begin @(negedge clk); n++; end
    wr(A_CLR, 1 << ch);
    check(pe_flag[ch] == 1'b0, "R11", $sformatf("ch%0d flag after clear", ch),
          int'(pe_flag[ch]), 0);
    n = 1;
    while (!pe_flag[ch] && n < 5000) begin @(negedge clk); n++; end
    check(n == exp, req, $sformatf("ch%0d period-end interval", ch), n, exp);
  endtask

  initial begin
    int p[NUM_CH];
    int d[NUM_CH];
    bit cen[NUM_CH];
    bit pl[NUM_CH];
    int bad[NUM_CH];
    void'($urandom(32'd20240611));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pwm_o == '0, "R1", "outputs after reset", int'(pwm_o), 0);
    check(pe_flag == '0, "R1", "flags after reset", int'(pe_flag), 0);

    // R5 stopped channel drives start level
    wr(A_BASE + 4*2, mk_mode(0, 1'b0, 1'b1, 1'b0));
    check(pwm_o[2] == 1'b1, "R5", "stopped ch2 with start level 1", int'(pwm_o[2]), 1);

    // R2 R3 R4 R5: random settings, all channels started by one write
    for (int it = 0; it < 6; it++) begin
      wr(A_STOP, 15);
      wr(A_CLR, 15);
      for (int c = 0; c < NUM_CH; c++) begin
        p[c]   = 2 + int'($urandom % 12);
        d[c]   = 1 + int'($urandom % (p[c] - 1));
        cen[c] = 1'($urandom % 2);
        pl[c]  = 1'($urandom % 2);
        cfg(c, mk_mode(0, cen[c], pl[c], 1'b0), p[c], d[c]);
      end
      wr(A_START, 15);
      for (int c = 0; c < NUM_CH; c++) bad[c] = -1;
      for (int j = 0; j < 40; j++) begin
        for (int c = 0; c < NUM_CH; c++)
          if (pwm_o[c] !== exp_level(cen[c], p[c], d[c], pl[c], j) && bad[c] < 0) bad[c] = j;
        @(negedge clk);
      end
      for (int c = 0; c < NUM_CH; c++)
        check(bad[c] < 0, "R2 R3 R4 R5",
              $sformatf("ch%0d in-phase waveform (center=%0d P=%0d D=%0d), first bad tick",
                        c, cen[c], p[c], d[c]), bad[c], -1);
      check(pe_flag == 4'hF, "R11", "all flags set after 40 ticks", int'(pe_flag), 15);
    end

    // R2: start of a running channel does not restart it
    wr(A_STOP, 15);
    cfg(0, mk_mode(0, 1'b0, 1'b0, 1'b0), 7, 3);
    wr(A_START, 1);
    repeat (2) @(negedge clk);
    wr(A_START, 1);
    check_wave(0, 3, 20, 1'b0, 7, 3, 1'b0, "R2");

    // R7: mode, period and duty writes ignored while running
    wr(A_STOP, 15);
    cfg(1, mk_mode(0, 1'b0, 1'b0, 1'b0), 5, 2);
    wr(A_START, 2);
    wr(A_BASE + 4*1 + 0, mk_mode(0, 1'b1, 1'b1, 1'b0));
    wr(A_BASE + 4*1 + 1, 9);
    wr(A_BASE + 4*1 + 2, 4);
    check_wave(1, 3, 20, 1'b0, 5, 2, 1'b0, "R7");

    // R8 R9: staged duty, last write wins, applied at the wrap
    wr(A_STOP, 15);
    cfg(0, mk_mode(0, 1'b0, 1'b0, 1'b0), 8, 2);
    wr(A_START, 1);
    repeat (3) @(negedge clk);
    wr(A_BASE + 3, 4);
    wr(A_BASE + 3, 5);
    check_wave(0, 5, 3, 1'b0, 8, 2, 1'b0, "R8");
    check_wave(0, 0, 16, 1'b0, 8, 5, 1'b0, "R8 R9");

    // R9: staged period
    wr(A_STOP, 15);
    cfg(0, mk_mode(0, 1'b0, 1'b0, 1'b1), 8, 3);
    wr(A_START, 1);
    repeat (2) @(negedge clk);
    wr(A_BASE + 3, 5);
    check_wave(0, 3, 5, 1'b0, 8, 3, 1'b0, "R8");
    check_wave(0, 0, 20, 1'b0, 5, 3, 1'b0, "R9");

    // R10: staged duty above the period is clamped
    wr(A_STOP, 15);
    cfg(0, mk_mode(0, 1'b0, 1'b0, 1'b0), 6, 2);
    wr(A_START, 1);
    @(negedge clk);
    wr(A_BASE + 3, 9);
    check_wave(0, 2, 4, 1'b0, 6, 2, 1'b0, "R8");
    check_wave(0, 0, 12, 1'b0, 6, 6, 1'b0, "R10");

    // R10: staged period below the duty lowers the duty
    wr(A_STOP, 15);
    cfg(0, mk_mode(0, 1'b0, 1'b0, 1'b1), 8, 6);
    wr(A_START, 1);
    wr(A_BASE + 3, 3);
    check_wave(0, 1, 7, 1'b0, 8, 6, 1'b0, "R8");
    check_wave(0, 0, 12, 1'b0, 3, 3, 1'b0, "R10");

    // R10 R11: period 0 stored as 1; a clear loses against a same-edge period end
    wr(A_STOP, 15);
    wr(A_CLR, 15);
    cfg(3, mk_mode(0, 1'b0, 1'b0, 1'b0), 0, 0);
    wr(A_START, 8);
    repeat (3) @(negedge clk);
    check(pwm_o[3] == 1'b1, "R10", "ch3 level with period 0 and duty 0", int'(pwm_o[3]), 1);
    wr(A_CLR, 8);
    check(pe_flag[3] == 1'b1, "R10 R11", "ch3 flag kept by same-edge period end",
          int'(pe_flag[3]), 1);

    // R6: divider settings, measured as period-end intervals
    wr(A_STOP, 15);
    wr(A_CLR, 15);
    cfg(0, mk_mode(3, 1'b0, 1'b0, 1'b0), 4, 1);
    wr(A_START, 1);
    measure(0, 32, "R6");
    wr(A_STOP, 15);
    wr(A_CLR, 15);
    cfg(1, mk_mode(1, 1'b1, 1'b0, 1'b0), 3, 1);
    wr(A_START, 2);
    measure(1, 12, "R4 R6");
    wr(A_STOP, 15);
    wr(A_CLR, 15);
    cfg(2, mk_mode(15, 1'b0, 1'b0, 1'b0), 2, 1);
    wr(A_START, 4);
    measure(2, 2048, "R6");

    // R5: stopping a channel returns it to its start level
    wr(A_STOP, 15);
    cfg(2, mk_mode(0, 1'b0, 1'b1, 1'b0), 4, 2);
    wr(A_START, 4);
    check_wave(2, 0, 8, 1'b0, 4, 2, 1'b1, "R5");
    wr(A_STOP, 4);
    begin
      int low_seen;
      low_seen = 0;
      for (int k = 0; k < 6; k++) begin
        if (pwm_o[2] !== 1'b1) low_seen++;
        @(negedge clk);
      end
      check(low_seen == 0, "R5", "stopped ch2 cycles off start level", low_seen, 0);
    end

    // R11: clear touches only the masked flag, others stay sticky
    wr(A_STOP, 15);
    cfg(0, mk_mode(0, 1'b0, 1'b0, 1'b0), 3, 1);
    wr(A_CLR, 15);
    wr(A_START, 3);
    repeat (30) @(negedge clk);
    wr(A_STOP, 3);
    check(pe_flag[1:0] == 2'b11, "R11", "flags of ch0/ch1 after running", int'(pe_flag[1:0]), 3);
    wr(A_CLR, 1);
    check(pe_flag[1:0] == 2'b10, "R11", "flags after clearing ch0 only", int'(pe_flag[1:0]), 2);
    repeat (10) @(negedge clk);
    check(pe_flag[1:0] == 2'b10, "R11", "flags stay while stopped", int'(pe_flag[1:0]), 2);

    summary();
  end
endmodule